// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block resolves a 32-bit bus address against a small bank of programmable address windows. Each window holds a base page, a size mask, a target identifier, an attribute byte and an enable bit. Addresses are compared in 64 KB pages: the upper 16 address bits are matched against the base under the window's size mask. A lookup returns, one clock later, a hit or miss flag, the index of the winning window, and that window's target and attribute.

Windows are set up through a simple write port. The port selects a window and a field code and carries a 16-bit data word. A size value must be a contiguous run of ones that starts at bit 0. Any other size value is refused, and a sticky error flag records the refusal. A separate converter turns a byte count into the matching size mask, so that software or a neighbouring block can derive a legal size value from a length in bytes.

Typical use is a system fabric that steers each processor access to a memory or peripheral target. Six windows are provided by default.

Top module: `addr_win_dec`

## Requirements
- R1: After reset, every window is disabled, `cfg_err` is 0, and all response outputs and `enc_mask` are 0.
- R2: A lookup presented with `lk_valid` high hits window w when w is enabled and (`lk_addr[31:16]` & ~size) equals (base & ~size). The response appears in the following cycle with `rsp_hit`=1, `rsp_win`=w, and that window's target and attribute.
- R3: A size value holding n ones from bit 0 covers 2^n pages of 64 KB each, aligned to that span. A size of 0 covers exactly one 64 KB page, and 0x00FF covers 16 MB.
- R4: When several enabled windows match the same address, the window with the lowest index wins.
- R5: A lookup that matches no window gives `rsp_miss`=1 and `rsp_hit`=0, with `rsp_win`, `rsp_target` and `rsp_attr` all 0.
- R6: A window whose enable bit is 0 never hits, whatever its base and size.
- R7: A size write whose data is not a run of ones from bit 0 leaves the stored size unchanged and sets `cfg_err`. `cfg_err` then stays 1 until reset.
- R8: One cycle after `enc_bytes` is applied, `enc_mask` has bit i set exactly when `enc_bytes >> (i+17)` is nonzero, for i from 0 to 15. For example, 16 MB gives 0x00FF, 128 MB gives 0x07FF, and 64 KB or less gives 0.
- R9: A write with `cfg_we`=1 updates field `cfg_sel` of window `cfg_win` at the clock edge. The field codes are 0 = base page, 1 = size, 2 = target (low 4 bits), 3 = attribute (low 8 bits) and 4 = enable (bit 0). Writes with any other code, or with a window index of 6 or more, change nothing. A lookup in the same cycle as a write sees the configuration from before that write.
- R10: `rsp_valid` equals the previous cycle's `lk_valid`. When `rsp_valid` is 0, `rsp_hit` and `rsp_miss` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_win | input | 3 | Window index for the write |
| cfg_sel | input | 3 | Field code for the write |
| cfg_wdata | input | 16 | Write data |
| cfg_err | output | 1 | Sticky flag: an illegal size value was refused |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Address to decode |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_hit | output | 1 | Address fell in an enabled window |
| rsp_miss | output | 1 | Address fell in no enabled window |
| rsp_win | output | 3 | Index of the winning window |
| rsp_target | output | 4 | Target identifier of the winning window |
| rsp_attr | output | 8 | Attribute byte of the winning window |
| enc_bytes | input | 32 | Byte count to convert into a size mask |
| enc_mask | output | 16 | Registered size mask for `enc_bytes` |

## Verification
The bench places addresses on the first and last page of each window and on the page just beyond it. A design with an off-by-one mask would hit one page too many or miss the top page. Overlapping windows are then disabled one at a time; a wrong priority direction reports the higher index, and an ignored enable keeps hitting. Malformed sizes such as 0x0101 and 0x8000 are written, which exposes a design that stores them or lets the error flag drop. The converter is driven at exact powers of two, one byte either side of them, and the full-scale value, which catches a mask that is shifted by one position.

// File: rtl/addr_win_pkg.sv
package addr_win_pkg;

    // Field codes on the configuration write port.
    typedef enum logic [2:0] {
        FLD_BASE   = 3'd0,
        FLD_SIZE   = 3'd1,
        FLD_TARGET = 3'd2,
        FLD_ATTR   = 3'd3,
        FLD_ENABLE = 3'd4
    } cfg_field_e;

    // log2 of the window page size in bytes (64 KB pages).
    localparam int PAGE_SHIFT = 16;

endpackage

// File: rtl/awd_size_enc.sv
// Byte count to size-mask converter. Bit i of the mask is set when the
// byte count halved once more than the page shift, then shifted by i,
// is still nonzero.
module awd_size_enc #(
    parameter int BYTES_W    = 32,
    parameter int MASK_W     = 16,
    parameter int PAGE_SHIFT = 16
) (
    input  logic [BYTES_W-1:0] bytes_i,
    output logic [MASK_W-1:0]  mask_o
);
    for (genvar i = 0; i < MASK_W; i++) begin : g_bit
        localparam int SH = i + PAGE_SHIFT + 1;
        if (SH < BYTES_W) begin : g_live
            assign mask_o[i] = |bytes_i[BYTES_W-1:SH];
        end else begin : g_dead
            assign mask_o[i] = 1'b0;
        end
    end

    // The low bits only decide sub-page sizes, which all map to a mask of 0.
    wire unused_low = ^bytes_i[PAGE_SHIFT:0];
endmodule

// File: rtl/awd_win_match.sv
// One window comparator: a page matches when every bit outside the size
// mask agrees with the base.
module awd_win_match #(
    parameter int PAGE_W = 16
) (
    input  logic              en_i,
    input  logic [PAGE_W-1:0] base_i,
    input  logic [PAGE_W-1:0] size_i,
    input  logic [PAGE_W-1:0] page_i,
    output logic              hit_o
);
    logic [PAGE_W-1:0] diff;

    always_comb begin
        diff  = (page_i ^ base_i) & ~size_i;
        hit_o = en_i && (diff == '0);
    end
endmodule

// File: rtl/awd_prio_sel.sv
// Lowest-index-first selector over the per-window match vector.
module awd_prio_sel #(
    parameter int N  = 6,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = IW'(i);
            end
        end
    end
endmodule

// File: rtl/addr_win_dec.sv
module addr_win_dec #(
    parameter int NUM_WIN = 6,
    parameter int ADDR_W  = 32,
    parameter int TGT_W   = 4,
    parameter int ATTR_W  = 8,
    localparam int IW     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
    localparam int PAGE_W = ADDR_W - addr_win_pkg::PAGE_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IW-1:0]     cfg_win,
    input  logic [2:0]        cfg_sel,
    input  logic [PAGE_W-1:0] cfg_wdata,
    output logic              cfg_err,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic [IW-1:0]     rsp_win,
    output logic [TGT_W-1:0]  rsp_target,
    output logic [ATTR_W-1:0] rsp_attr,
    input  logic [ADDR_W-1:0] enc_bytes,
    output logic [PAGE_W-1:0] enc_mask
);
    import addr_win_pkg::*;

    typedef struct packed {
        logic              en;
        logic [PAGE_W-1:0] base;
        logic [PAGE_W-1:0] size;
        logic [TGT_W-1:0]  tgt;
        logic [ATTR_W-1:0] attr;
    } win_t;

    typedef struct packed {
        win_t [NUM_WIN-1:0] win;
        logic               err;
        logic               rv;
        logic               hit;
        logic               miss;
        logic [IW-1:0]      idx;
        logic [TGT_W-1:0]   tgt;
        logic [ATTR_W-1:0]  attr;
        logic [PAGE_W-1:0]  enc;
    } state_t;

    state_t st_d, st_q;

    // ---------------- per-window comparators ----------------
    logic [PAGE_W-1:0]  page;
    logic [NUM_WIN-1:0] match;
    logic               any_match;
    logic [IW-1:0]      sel_idx;
    logic [PAGE_W-1:0]  enc_next;

    assign page = lk_addr[ADDR_W-1 -: PAGE_W];
    wire unused_offset = ^lk_addr[PAGE_SHIFT-1:0];

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        awd_win_match #(.PAGE_W(PAGE_W)) u_match (
            .en_i   (st_q.win[w].en),
            .base_i (st_q.win[w].base),
            .size_i (st_q.win[w].size),
            .page_i (page),
            .hit_o  (match[w])
        );
    end

    awd_prio_sel #(.N(NUM_WIN), .IW(IW)) u_prio (
        .req_i (match),
        .any_o (any_match),
        .idx_o (sel_idx)
    );

    awd_size_enc #(
        .BYTES_W    (ADDR_W),
        .MASK_W     (PAGE_W),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_enc (
        .bytes_i (enc_bytes),
        .mask_o  (enc_next)
    );

    // ---------------- next-state logic ----------------
    logic              win_ok;
    logic              size_ok;
    logic [PAGE_W:0]   size_inc;
    win_t              hit_win;

    always_comb begin
        st_d = st_q;

        // Size legality: a run of ones from bit 0 has no bit in common
        // with its own increment.
        size_inc = {1'b0, cfg_wdata} + 1'b1;
        size_ok  = (size_inc[PAGE_W-1:0] & cfg_wdata) == '0;
        win_ok   = ({1'b0, cfg_win} < (IW + 1)'(NUM_WIN));

        if (cfg_we && win_ok) begin
            case (cfg_sel)
                FLD_BASE:   st_d.win[cfg_win].base = cfg_wdata;
                FLD_SIZE: begin
                    if (size_ok) begin
                        st_d.win[cfg_win].size = cfg_wdata;
                    end else begin
                        st_d.err = 1'b1;
                    end
                end
                FLD_TARGET: st_d.win[cfg_win].tgt  = cfg_wdata[TGT_W-1:0];
                FLD_ATTR:   st_d.win[cfg_win].attr = cfg_wdata[ATTR_W-1:0];
                FLD_ENABLE: st_d.win[cfg_win].en   = cfg_wdata[0];
                default: ;
            endcase
        end

        // Lookup response, decoded from the configuration before any write
        // in this cycle.
        hit_win   = st_q.win[sel_idx];
        st_d.rv   = lk_valid;
        st_d.hit  = lk_valid && any_match;
        st_d.miss = lk_valid && !any_match;
        if (lk_valid && any_match) begin
            st_d.idx  = sel_idx;
            st_d.tgt  = hit_win.tgt;
            st_d.attr = hit_win.attr;
        end else begin
            st_d.idx  = '0;
            st_d.tgt  = '0;
            st_d.attr = '0;
        end

        st_d.enc = enc_next;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_err    = st_q.err;
    assign rsp_valid  = st_q.rv;
    assign rsp_hit    = st_q.hit;
    assign rsp_miss   = st_q.miss;
    assign rsp_win    = st_q.idx;
    assign rsp_target = st_q.tgt;
    assign rsp_attr   = st_q.attr;
    assign enc_mask   = st_q.enc;
endmodule

// File: rtl/addr_win_dec_chk.sv
module addr_win_dec_chk #(
    parameter int IW     = 3,
    parameter int TGT_W  = 4,
    parameter int ATTR_W = 8,
    parameter int PAGE_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [2:0]        cfg_sel,
    input logic              cfg_err,
    input logic              lk_valid,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_miss,
    input logic [IW-1:0]     rsp_win,
    input logic [TGT_W-1:0]  rsp_target,
    input logic [ATTR_W-1:0] rsp_attr,
    input logic [PAGE_W-1:0] enc_mask
);
    // R10: the response strobe follows the request by one cycle.
    a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    a_r10_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);

    // R10: a valid response is exactly one of hit or miss; none when idle.
    a_r10_hit_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot({rsp_hit, rsp_miss}));
    a_r10_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_hit && !rsp_miss);

    // R5: a miss carries zero window, target and attribute.
    a_r5_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_win == '0) && (rsp_target == '0) && (rsp_attr == '0));

    // R7: the error flag is sticky and only a size write can raise it.
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);
    a_r7_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> $past(cfg_we) && ($past(cfg_sel) == 3'd1));

    // R8: the converter always yields a run of ones from bit 0.
    a_r8_enc_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (({1'b0, enc_mask} + 1'b1) & {1'b0, enc_mask}) == '0);
endmodule

bind addr_win_dec addr_win_dec_chk #(
    .IW     (IW),
    .TGT_W  (TGT_W),
    .ATTR_W (ATTR_W),
    .PAGE_W (PAGE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_err    (cfg_err),
    .lk_valid   (lk_valid),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_miss   (rsp_miss),
    .rsp_win    (rsp_win),
    .rsp_target (rsp_target),
    .rsp_attr   (rsp_attr),
    .enc_mask   (enc_mask)
);

// File: tb/addr_win_dec_tb.sv
module addr_win_dec_tb;
    localparam int NW = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_win = '0;
    logic [2:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic        cfg_err;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        rsp_valid, rsp_hit, rsp_miss;
    logic [2:0]  rsp_win;
    logic [3:0]  rsp_target;
    logic [7:0]  rsp_attr;
    logic [31:0] enc_bytes = '0;
    logic [15:0] enc_mask;

    always #5 clk = ~clk;

    addr_win_dec u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_win(cfg_win),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_err(cfg_err),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_win(rsp_win),
        .rsp_target(rsp_target), .rsp_attr(rsp_attr),
        .enc_bytes(enc_bytes), .enc_mask(enc_mask)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    int    n_cyc = 0;
    string cur_req = "R6";

    // ---------------- reference model ----------------
    bit          m_en   [NW];
    bit [15:0]   m_base [NW];
    bit [15:0]   m_size [NW];
    bit [3:0]    m_tgt  [NW];
    bit [7:0]    m_attr [NW];
    bit          m_err;
    bit          e_rv, e_hit, e_miss;
    int          e_win;
    bit [3:0]    e_tgt;
    bit [7:0]    e_attr;
    bit [15:0]   e_enc;

    function automatic bit legal_size(bit [15:0] v);
        bit seen_zero = 0;
        for (int b = 0; b < 16; b++) begin
            if (!v[b]) seen_zero = 1;
            else if (seen_zero) return 0;
        end
        return 1;
    endfunction

    function automatic bit [15:0] size_of_bytes(bit [31:0] bytes);
        bit [31:0] val = bytes >> 1;
        bit [31:0] j = 0;
        for (int i = 0; val >= 32'h10000; i++) begin
            j |= (32'd1 << i);
            val >>= 1;
        end
        return j[15:0];
    endfunction

    function automatic int find_win(bit [31:0] a);
        for (int w = 0; w < NW; w++) begin
            if (m_en[w] && (((a[31:16] ^ m_base[w]) & ~m_size[w]) == 16'h0))
                return w;
        end
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NW; w++) begin
                m_en[w] <= 0; m_base[w] <= 0; m_size[w] <= 0;
                m_tgt[w] <= 0; m_attr[w] <= 0;
            end
            m_err <= 0; e_rv <= 0; e_hit <= 0; e_miss <= 0;
            e_win <= 0; e_tgt <= 0; e_attr <= 0; e_enc <= 0;
        end else begin
            int f;
            f = lk_valid ? find_win(lk_addr) : -1;
            e_rv   <= lk_valid;
            e_hit  <= lk_valid && (f >= 0);
            e_miss <= lk_valid && (f < 0);
            e_win  <= (f >= 0) ? f : 0;
            e_tgt  <= (f >= 0) ? m_tgt[f] : 4'h0;
            e_attr <= (f >= 0) ? m_attr[f] : 8'h0;
            e_enc  <= size_of_bytes(enc_bytes);
            if (cfg_we && (int'(cfg_win) < NW)) begin
                case (cfg_sel)
                    3'd0: m_base[cfg_win] <= cfg_wdata;
                    3'd1: if (legal_size(cfg_wdata)) m_size[cfg_win] <= cfg_wdata;
                          else m_err <= 1;
                    3'd2: m_tgt[cfg_win]  <= cfg_wdata[3:0];
                    3'd3: m_attr[cfg_win] <= cfg_wdata[7:0];
                    3'd4: m_en[cfg_win]   <= cfg_wdata[0];
                    default: ;
                endcase
            end
        end
    end

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check("R10", "rsp_valid", int'(rsp_valid), int'(e_rv));
            check(e_miss ? "R5" : cur_req, "rsp_hit", int'(rsp_hit), int'(e_hit));
            check(e_miss ? "R5" : cur_req, "rsp_miss", int'(rsp_miss), int'(e_miss));
            check(e_miss ? "R5" : cur_req, "rsp_win", int'(rsp_win), e_win);
            check(e_miss ? "R5" : cur_req, "rsp_target", int'(rsp_target), int'(e_tgt));
            check(e_miss ? "R5" : cur_req, "rsp_attr", int'(rsp_attr), int'(e_attr));
            check("R7", "cfg_err", int'(cfg_err), int'(m_err));
            check("R8", "enc_mask", int'(enc_mask), int'(e_enc));
        end
    end

    // ---------------- stimulus ----------------
    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(int w, int s, int d);
        cfg_we = 1; cfg_win = 3'(w); cfg_sel = 3'(s); cfg_wdata = 16'(d);
        cyc();
        cfg_we = 0;
    endtask

    task automatic setup(int w, int base, int size, int tgt, int attr);
        wr(w, 0, base); wr(w, 1, size); wr(w, 2, tgt); wr(w, 3, attr); wr(w, 4, 1);
    endtask

    task automatic look(bit [31:0] a, string req);
        lk_valid = 1; lk_addr = a; cur_req = req;
        cyc();
        lk_valid = 0;
    endtask

    task automatic conv(bit [31:0] b);
        enc_bytes = b;
        cyc();
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > 50000) begin
            n_chk++; n_fail++;
            $display("FAIL R10 watchdog: actual %0d cycles expected below 50000", n_cyc);
            summary();
            $finish;
        end
    end

    initial begin
        cyc(); cyc(); cyc();
        // R1: reset state at the ports while reset is held.
        check("R1", "rsp_valid", int'(rsp_valid), 0);
        check("R1", "rsp_hit", int'(rsp_hit), 0);
        check("R1", "rsp_miss", int'(rsp_miss), 0);
        check("R1", "cfg_err", int'(cfg_err), 0);
        check("R1", "enc_mask", int'(enc_mask), 0);
        rst_n = 1;
        cyc();
        // R1/R6: after reset all windows are disabled, so any address misses.
        look(32'h0000_0000, "R1");
        look(32'hF000_0000, "R6");
        // R6: a fully programmed window stays silent until enabled.
        wr(0, 0, 16'hF000); wr(0, 1, 16'h00FF);
        look(32'hF000_1234, "R6");
        // R2/R3: 16 MB window at 0xF0000000, edges and just beyond.
        setup(0, 16'hF000, 16'h00FF, 1, 8'hE8);
        look(32'hF000_0000, "R3");
        look(32'hF0FF_FFFC, "R3");
        look(32'hF100_0000, "R3");
        look(32'hEFFF_FFFF, "R3");
        // R3: size 0 is a single 64 KB page.
        setup(1, 16'hF100, 16'h0000, 2, 8'h5A);
        look(32'hF100_FFFF, "R3");
        look(32'hF101_0000, "R3");
        look(32'hF100_8000, "R2");
        // R4: overlapping windows, lowest index wins.
        setup(2, 16'hF000, 16'h000F, 3, 8'h11);
        setup(5, 16'hF000, 16'h7FFF, 9, 8'h99);
        look(32'hF000_4000, "R4");
        look(32'hF00F_0000, "R4");
        wr(0, 4, 0);
        look(32'hF000_4000, "R4");
        look(32'hF010_0000, "R4");
        wr(2, 4, 0);
        look(32'hF000_4000, "R6");
        look(32'hC000_0000, "R4");
        // R9: a lookup in the same cycle as a write sees the old setting.
        cfg_we = 1; cfg_win = 3'd2; cfg_sel = 3'd4; cfg_wdata = 16'h0001;
        look(32'hF000_4000, "R9");
        cfg_we = 0;
        look(32'hF000_4000, "R9");
        // R7: malformed sizes are refused and the flag sticks.
        wr(2, 1, 16'h0101);
        look(32'hF00F_0000, "R7");
        look(32'hF010_0000, "R7");
        wr(2, 1, 16'h8000);
        wr(2, 1, 16'h0003);
        look(32'hF003_0000, "R7");
        look(32'hF004_0000, "R7");
        // R9: unused field codes and out-of-range windows change nothing.
        wr(2, 5, 16'h0000);
        wr(2, 7, 16'hFFFF);
        wr(6, 4, 16'h0001);
        wr(7, 2, 16'h000F);
        look(32'hF000_0000, "R9");
        look(32'hF004_0000, "R9");
        // R8: byte count conversion around powers of two.
        conv(32'h0000_0000);
        conv(32'h0001_0000);
        conv(32'h0001_FFFF);
        conv(32'h0002_0000);
        conv(32'h0003_FFFF);
        conv(32'h0004_0000);
        conv(32'h0100_0000);
        conv(32'h00FF_FFFF);
        conv(32'h0800_0000);
        conv(32'h8000_0000);
        conv(32'hFFFF_FFFF);
        for (int k = 0; k < 40; k++) conv($urandom);
        // R2: mixed random traffic with interleaved writes.
        for (int k = 0; k < 300; k++) begin
            bit [31:0] a = $urandom;
            case (k % 4)
                0: a[31:24] = 8'hF0;
                1: a[31:16] = 16'hF100;
                2: a[31:28] = 4'hF;
                default: ;
            endcase
            if (k % 37 == 0) begin
                cfg_we = 1; cfg_win = 3'($urandom_range(0, 7));
                cfg_sel = 3'($urandom_range(0, 5)); cfg_wdata = 16'($urandom);
            end
            enc_bytes = $urandom;
            look(a, "R2");
            cfg_we = 0;
        end
        cyc(); cyc();
        summary();
        $finish;
    end
endmodule